// File: doc/BRIEF.md
# Dual-Issue Fetch and Branch Resolver

This block is the front end of a small in-order-fetch pipeline. Every cycle it reads up to two consecutive 32-bit words from instruction memory, beginning at its program counter. It decodes them and sends each ordinary instruction to a four-entry pre-issue queue, oldest first. Control transfers are resolved in this stage. There is no prediction and no delay slot. The block reads the branch operands from the register file and checks them against the busy bits of the scoreboard. When an operand is still being produced, the branch is parked in a waiting register and fetch stops until the operand is ready. A halt instruction stops fetch for good.

The queue side is a push stream. The free-slot count acts as the ready signal. It is sampled as it stood at the end of the previous cycle and is never combined with a handshake in the same cycle. With zero free slots nothing is fetched. With one free slot at most one word is fetched. With two or more, up to two words are fetched. A push that the block raises is always accepted, because it never offers more than the count allowed. The two push lanes are in program order, so lane 0 is older whenever both are valid. Instruction memory and register-file reads are combinational, and their results are used in the same cycle.

Instruction encoding (opcode in bits 31:26, first source register in 25:21, second in 20:16, immediate in 15:0): the all-zero word is a no-op. Opcode 0x02 is an absolute jump, 0x03 jumps to a register value, 0x04 branches if the two sources are equal, 0x05 branches if the first source is negative, 0x06 branches if it is positive, and 0x07 halts. Every other word is an ordinary instruction.

Top module: `dual_fetch_unit`

## Requirements
- R1: After reset the fetch address `imem_addr0` is 256, `halted` is 0 and `wait_valid` is 0.
- R2: When at least two slots are free and neither word is a control word, both words are pushed: lane 0 carries the word at the PC, lane 1 the word at PC+4. The PC then advances by 8.
- R3: With `q_free` = 0 nothing is pushed and the PC holds. With `q_free` = 1 at most lane 0 is used and the PC advances by 4.
- R4: A no-op (all-zero word) is never pushed, but it still uses a fetch slot and advances the PC.
- R5: An absolute jump (opcode 0x02) takes effect in the cycle it is fetched. The next PC is bits 31:28 of (jump address + 4), followed by the 26-bit index and then two zero bits.
- R6: When the first fetched word is a branch, jump or halt, the second word is dropped and is not pushed.
- R7: When the second fetched word is a branch, the first word is pushed normally and the branch is resolved in the same cycle.
- R8: A conditional branch (0x04 equal, 0x05 less than zero, 0x06 greater than zero, signed compares) goes to branch address + 4 + (sign-extended immediate × 4) when its condition holds. Otherwise it goes to branch address + 4.
- R9: A register jump (opcode 0x03) sets the PC to the value of its first source register.
- R10: When a source of a fetched branch is marked busy, `wait_valid` rises and `wait_instr` holds the branch. Nothing is fetched or pushed until the cycle after the branch resolves, and the resolving cycle itself fetches nothing.
- R11: When a halt word (opcode 0x07) is fetched, `halted` rises and stays high, and no later word is pushed. An ordinary word ahead of the halt in the same pair is still pushed.
- R12: A waiting branch is evaluated with the register values presented in the cycle its operands become ready, not with the values from when it was fetched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_addr0 | output | 32 | Byte address of the first fetch word (the PC) |
| imem_addr1 | output | 32 | Byte address of the second fetch word |
| imem_data0 | input | 32 | Word at `imem_addr0` |
| imem_data1 | input | 32 | Word at `imem_addr1` |
| rf_raddr_a | output | 5 | Register-file read index, first branch source |
| rf_raddr_b | output | 5 | Register-file read index, second branch source |
| rf_rdata_a | input | 32 | Value of register `rf_raddr_a` at the end of the previous cycle |
| rf_rdata_b | input | 32 | Value of register `rf_raddr_b` at the end of the previous cycle |
| reg_busy | input | 32 | Scoreboard: bit n set means register n has a pending write |
| q_free | input | 3 | Free pre-issue slots at the end of the previous cycle |
| push0_valid | output | 1 | Lane 0 push (older) |
| push0_instr | output | 32 | Lane 0 instruction |
| push1_valid | output | 1 | Lane 1 push (younger) |
| push1_instr | output | 32 | Lane 1 instruction |
| halted | output | 1 | Halt word has been fetched |
| wait_valid | output | 1 | A branch is waiting for its operands |
| wait_instr | output | 32 | The waiting branch word |

## Verification
The bench sweeps every free-slot count from 0 to 4. A design that ignored the count would push into a full queue, and one that did not limit a single free slot would raise lane 1. All three conditional branches are swept across a grid of small signed operand values, with both a forward and a backward offset. This exposes unsigned compares, off-by-one in the offset base, or a missing sign extension as a wrong next address. Control words are placed in both lanes. A unit that failed to drop the word after a leading branch would push it, and one that mishandled a trailing branch would lose the older instruction. For a stalled branch, the operand value is changed while the branch waits. A design that latched operands at fetch time, or fetched during the resolving cycle, would show the wrong next address or a stray push.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
  localparam int INSTR_W = 32;
  localparam int RIDX_W  = 5;

  localparam logic [5:0] OPC_JUMP = 6'h02;
  localparam logic [5:0] OPC_JREG = 6'h03;
  localparam logic [5:0] OPC_BEQ  = 6'h04;
  localparam logic [5:0] OPC_BLTZ = 6'h05;
  localparam logic [5:0] OPC_BGTZ = 6'h06;
  localparam logic [5:0] OPC_HALT = 6'h07;

  typedef enum logic [2:0] {
    K_PLAIN, K_NOP, K_JUMP, K_JREG, K_BEQ, K_BLTZ, K_BGTZ, K_HALT
  } ikind_e;

  typedef struct packed {
    ikind_e            kind;
    logic              is_branch;
    logic              is_halt;
    logic              pushable;
    logic              use_a;
    logic              use_b;
    logic [RIDX_W-1:0] src_a;
    logic [RIDX_W-1:0] src_b;
  } dec_t;
endpackage

// File: rtl/fetch_decoder.sv
module fetch_decoder
  import fetch_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output dec_t               dec_o
);
  ikind_e k;

  always_comb begin
    if (instr_i == '0) k = K_NOP;
    else begin
      unique case (instr_i[31:26])
        OPC_JUMP: k = K_JUMP;
        OPC_JREG: k = K_JREG;
        OPC_BEQ:  k = K_BEQ;
        OPC_BLTZ: k = K_BLTZ;
        OPC_BGTZ: k = K_BGTZ;
        OPC_HALT: k = K_HALT;
        default:  k = K_PLAIN;
      endcase
    end
  end

  always_comb begin
    dec_o.kind      = k;
    dec_o.is_branch = (k == K_JUMP) || (k == K_JREG) || (k == K_BEQ) ||
                      (k == K_BLTZ) || (k == K_BGTZ);
    dec_o.is_halt   = (k == K_HALT);
    dec_o.pushable  = (k == K_PLAIN);
    dec_o.use_a     = (k == K_JREG) || (k == K_BEQ) || (k == K_BLTZ) || (k == K_BGTZ);
    dec_o.use_b     = (k == K_BEQ);
    dec_o.src_a     = instr_i[25:21];
    dec_o.src_b     = instr_i[20:16];
  end
endmodule

// File: rtl/branch_resolver.sv
module branch_resolver
  import fetch_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  ikind_e             kind_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [ADDR_W-1:0]  br_pc_i,
  input  logic [ADDR_W-1:0]  val_a_i,
  input  logic [ADDR_W-1:0]  val_b_i,
  output logic [ADDR_W-1:0]  next_pc_o
);
  localparam int IMM_W = 16;
  localparam int IDX_W = 26;
  localparam int HI_W  = ADDR_W - IDX_W - 2;

  logic [ADDR_W-1:0] seq_pc;
  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] rel_tgt;
  logic              a_neg;
  logic              a_zero;

  assign seq_pc  = br_pc_i + ADDR_W'(4);
  assign offset  = {{(ADDR_W-IMM_W-2){instr_i[IMM_W-1]}}, instr_i[IMM_W-1:0], 2'b00};
  assign rel_tgt = seq_pc + offset;
  assign a_neg   = val_a_i[ADDR_W-1];
  assign a_zero  = (val_a_i == '0);

  always_comb begin
    unique case (kind_i)
      K_JUMP:  next_pc_o = {seq_pc[ADDR_W-1 -: HI_W], instr_i[IDX_W-1:0], 2'b00};
      K_JREG:  next_pc_o = val_a_i;
      K_BEQ:   next_pc_o = (val_a_i == val_b_i) ? rel_tgt : seq_pc;
      K_BLTZ:  next_pc_o = a_neg ? rel_tgt : seq_pc;
      K_BGTZ:  next_pc_o = (!a_neg && !a_zero) ? rel_tgt : seq_pc;
      default: next_pc_o = seq_pc;
    endcase
  end
endmodule

// File: rtl/dual_fetch_unit.sv
module dual_fetch_unit
  import fetch_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter int          NREG     = 32,
  parameter int          Q_DEPTH  = 4,
  parameter logic [31:0] RESET_PC = 32'd256,
  localparam int         REG_AW   = $clog2(NREG),
  localparam int         FREE_W   = $clog2(Q_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic [DATA_W-1:0]  imem_addr0,
  output logic [DATA_W-1:0]  imem_addr1,
  input  logic [INSTR_W-1:0] imem_data0,
  input  logic [INSTR_W-1:0] imem_data1,
  output logic [REG_AW-1:0]  rf_raddr_a,
  output logic [REG_AW-1:0]  rf_raddr_b,
  input  logic [DATA_W-1:0]  rf_rdata_a,
  input  logic [DATA_W-1:0]  rf_rdata_b,
  input  logic [NREG-1:0]    reg_busy,
  input  logic [FREE_W-1:0]  q_free,
  output logic               push0_valid,
  output logic [INSTR_W-1:0] push0_instr,
  output logic               push1_valid,
  output logic [INSTR_W-1:0] push1_instr,
  output logic               halted,
  output logic               wait_valid,
  output logic [INSTR_W-1:0] wait_instr
);
  localparam int LANES = 2;
  localparam logic [DATA_W-1:0] STEP = DATA_W'(4);

  logic [DATA_W-1:0]  pc_q, wait_pc_q;
  logic [INSTR_W-1:0] wait_word_q;
  logic               wait_q, halt_q;

  logic [INSTR_W-1:0] word [LANES];
  dec_t               dec  [LANES];

  assign word[0] = imem_data0;
  assign word[1] = imem_data1;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    fetch_decoder u_dec (.instr_i(word[g]), .dec_o(dec[g]));
  end

  logic fetch_en, pair_ok, take1;
  assign fetch_en = !halt_q && !wait_q && (q_free != '0);
  assign pair_ok  = (q_free >= FREE_W'(2));
  assign take1    = fetch_en && pair_ok && !dec[0].is_branch && !dec[0].is_halt;

  // Select the one branch that may be resolved this cycle.
  logic               br_act;
  logic [INSTR_W-1:0] br_word;
  logic [DATA_W-1:0]  br_pc;
  dec_t               br_dec;

  always_comb begin
    br_act  = 1'b0;
    br_word = wait_word_q;
    br_pc   = wait_pc_q;
    if (wait_q) begin
      br_act = 1'b1;
    end else if (fetch_en && dec[0].is_branch) begin
      br_act  = 1'b1;
      br_word = imem_data0;
      br_pc   = pc_q;
    end else if (take1 && dec[1].is_branch) begin
      br_act  = 1'b1;
      br_word = imem_data1;
      br_pc   = pc_q + STEP;
    end
  end

  fetch_decoder u_brdec (.instr_i(br_word), .dec_o(br_dec));

  assign rf_raddr_a = REG_AW'(br_dec.src_a);
  assign rf_raddr_b = REG_AW'(br_dec.src_b);

  logic br_ready;
  assign br_ready = !(br_dec.use_a && reg_busy[rf_raddr_a]) &&
                    !(br_dec.use_b && reg_busy[rf_raddr_b]);

  logic [DATA_W-1:0] br_next;
  branch_resolver #(.ADDR_W(DATA_W)) u_res (
    .kind_i   (br_dec.kind),
    .instr_i  (br_word),
    .br_pc_i  (br_pc),
    .val_a_i  (rf_rdata_a),
    .val_b_i  (rf_rdata_b),
    .next_pc_o(br_next)
  );

  logic halt_seen;
  assign halt_seen = fetch_en && (dec[0].is_halt || (take1 && dec[1].is_halt));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q        <= RESET_PC[DATA_W-1:0];
      wait_q      <= 1'b0;
      wait_word_q <= '0;
      wait_pc_q   <= '0;
      halt_q      <= 1'b0;
    end else begin
      if (br_act && br_ready) begin
        pc_q   <= br_next;
        wait_q <= 1'b0;
      end else if (br_act) begin
        wait_q      <= 1'b1;
        wait_word_q <= br_word;
        wait_pc_q   <= br_pc;
      end else if (fetch_en) begin
        pc_q <= pc_q + (take1 ? (STEP + STEP) : STEP);
      end
      if (halt_seen) halt_q <= 1'b1;
    end
  end

  assign imem_addr0  = pc_q;
  assign imem_addr1  = pc_q + STEP;
  assign push0_valid = fetch_en && dec[0].pushable;
  assign push0_instr = imem_data0;
  assign push1_valid = take1 && dec[1].pushable;
  assign push1_instr = imem_data1;
  assign halted      = halt_q;
  assign wait_valid  = wait_q;
  assign wait_instr  = wait_word_q;
endmodule

// File: rtl/dual_fetch_unit_chk.sv
module dual_fetch_unit_chk #(
  parameter int FREE_W = 3,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [FREE_W-1:0] q_free,
  input logic              push0_valid,
  input logic              push1_valid,
  input logic              halted,
  input logic              wait_valid,
  input logic [31:0]       wait_instr,
  input logic [DATA_W-1:0] imem_addr0
);
  // R3
  full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_free == '0) |-> (!push0_valid && !push1_valid));
  // R3
  single_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_free == FREE_W'(1)) |-> !push1_valid);
  // R11
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);
  // R11
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!push0_valid && !push1_valid));
  // R11
  halt_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> $stable(imem_addr0));
  // R10
  stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wait_valid |-> (!push0_valid && !push1_valid));
  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wait_valid |=> (!wait_valid || $stable(wait_instr)));
  // R10
  stall_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wait_valid |=> (!wait_valid || $stable(imem_addr0)));
endmodule

bind dual_fetch_unit dual_fetch_unit_chk #(.FREE_W(FREE_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .q_free     (q_free),
  .push0_valid(push0_valid),
  .push1_valid(push1_valid),
  .halted     (halted),
  .wait_valid (wait_valid),
  .wait_instr (wait_instr),
  .imem_addr0 (imem_addr0)
);

// File: tb/dual_fetch_unit_test.sv
`timescale 1ns/1ps
module dual_fetch_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] imem_addr0, imem_addr1, imem_data0, imem_data1;
  logic [4:0]  rf_raddr_a, rf_raddr_b;
  logic [31:0] rf_rdata_a, rf_rdata_b;
  logic [31:0] reg_busy = '0;
  logic [2:0]  q_free = 3'd4;
  logic        push0_valid, push1_valid, halted, wait_valid;
  logic [31:0] push0_instr, push1_instr, wait_instr;

  logic [31:0] prog [64];
  logic [31:0] regs [32];
  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  always_comb begin
    imem_data0 = prog[imem_addr0[7:2] - 6'd0];
    imem_data1 = prog[imem_addr1[7:2]];
    rf_rdata_a = regs[rf_raddr_a];
    rf_rdata_b = regs[rf_raddr_b];
  end

  dual_fetch_unit uut (.*);

  function automatic logic [31:0] plain(input int k);
    return {6'h20, 26'(k)};
  endfunction
  function automatic logic [31:0] enc(input logic [5:0] op, input int ra, input int rb, input int imm);
    return {op, 5'(ra), 5'(rb), 16'(imm)};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Program indices are relative to 256 (index 0 = address 256); prog wraps over 64 words.
  task automatic restart();
    rst_n = 1'b0;
    reg_busy = '0;
    q_free = 3'd4;
    for (int i = 0; i < 64; i++) prog[i] = plain(i + 1);
    for (int i = 0; i < 32; i++) regs[i] = '0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic edge_step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1 reset state
    restart();
    #1;
    chk("R1", "pc", imem_addr0, 32'd256);
    chk("R1", "halted", {31'd0, halted}, 0);
    chk("R1", "wait", {31'd0, wait_valid}, 0);

    // R2 two ordinary words
    restart();
    #1;
    chk("R2", "push0_valid", {31'd0, push0_valid}, 1);
    chk("R2", "push0_instr", push0_instr, plain(1));
    chk("R2", "push1_valid", {31'd0, push1_valid}, 1);
    chk("R2", "push1_instr", push1_instr, plain(2));
    edge_step();
    chk("R2", "pc+8", imem_addr0, 32'd264);

    // R3 sweep of free-slot counts
    for (int f = 0; f <= 4; f++) begin
      restart();
      q_free = 3'(f);
      #1;
      chk("R3", "push0_valid", {31'd0, push0_valid}, (f >= 1) ? 1 : 0);
      chk("R3", "push1_valid", {31'd0, push1_valid}, (f >= 2) ? 1 : 0);
      edge_step();
      chk("R3", "pc", imem_addr0, 32'(256 + 4 * ((f > 2) ? 2 : f)));
    end

    // R4 no-op first, ordinary second
    restart();
    prog[0] = '0;
    #1;
    chk("R4", "nop not pushed", {31'd0, push0_valid}, 0);
    chk("R4", "next pushed", {31'd0, push1_valid}, 1);
    chk("R4", "next instr", push1_instr, plain(2));
    edge_step();
    chk("R4", "pc", imem_addr0, 32'd264);

    // R5 R6 jump first drops second
    restart();
    prog[0] = {6'h02, 26'h50};
    #1;
    chk("R6", "push0", {31'd0, push0_valid}, 0);
    chk("R6", "dropped", {31'd0, push1_valid}, 0);
    edge_step();
    chk("R5", "jump target", imem_addr0, 32'd320);
    chk("R5", "no wait", {31'd0, wait_valid}, 0);
    #1;
    chk("R6", "refetch at target", push0_instr, plain(17));

    // R7 branch second
    restart();
    prog[1] = {6'h02, 26'h50};
    #1;
    chk("R7", "older pushed", {31'd0, push0_valid}, 1);
    chk("R7", "older instr", push0_instr, plain(1));
    chk("R7", "branch not pushed", {31'd0, push1_valid}, 0);
    edge_step();
    chk("R7", "target", imem_addr0, 32'd320);

    // R8 conditional sweep, forward (+3) and backward (-1) offsets
    for (int op = 0; op < 3; op++)
      for (int a = -2; a <= 2; a++)
        for (int b = -2; b <= 2; b++)
          for (int dir = 0; dir < 2; dir++) begin
            bit taken;
            int imm;
            if (op != 0 && b != 0) continue;
            imm = dir ? -1 : 3;
            restart();
            regs[1] = 32'(a);
            regs[2] = 32'(b);
            prog[0] = enc(6'(4 + op), 1, 2, imm);
            taken = (op == 0) ? (a == b) : (op == 1) ? (a < 0) : (a > 0);
            #1;
            chk("R8", "no push", {31'd0, push0_valid | push1_valid}, 0);
            edge_step();
            chk("R8", "next pc", imem_addr0, taken ? 32'(260 + 4 * imm) : 32'd260);
          end

    // R9 register jump
    restart();
    regs[5] = 32'h200;
    prog[0] = enc(6'h03, 5, 0, 0);
    #1;
    edge_step();
    chk("R9", "jr target", imem_addr0, 32'h200);

    // R10 R12 stall on busy operand, branch in lane 1
    for (int eq = 0; eq < 2; eq++) begin
      restart();
      regs[1] = 32'd5;
      regs[2] = 32'd5;
      reg_busy[2] = 1'b1;
      prog[1] = enc(6'h04, 1, 2, 3);
      #1;
      chk("R10", "older pushed", {31'd0, push0_valid}, 1);
      chk("R10", "branch not pushed", {31'd0, push1_valid}, 0);
      edge_step();
      chk("R10", "wait_valid", {31'd0, wait_valid}, 1);
      chk("R10", "wait_instr", wait_instr, enc(6'h04, 1, 2, 3));
      chk("R10", "stalled no push", {31'd0, push0_valid | push1_valid}, 0);
      edge_step();
      chk("R10", "still waiting", {31'd0, wait_valid}, 1);
      reg_busy[2] = 1'b0;
      regs[1] = eq ? 32'd5 : 32'd9;
      #1;
      chk("R10", "resolve cycle no push", {31'd0, push0_valid | push1_valid}, 0);
      edge_step();
      chk("R10", "wait cleared", {31'd0, wait_valid}, 0);
      chk("R12", "late operand pc", imem_addr0, eq ? 32'd276 : 32'd264);
      chk("R10", "fetch resumes", {31'd0, push0_valid}, 1);
    end

    // R11 halt second: older pushed, then silent
    restart();
    prog[1] = {6'h07, 26'd0};
    #1;
    chk("R11", "older pushed", {31'd0, push0_valid}, 1);
    chk("R11", "halt not pushed", {31'd0, push1_valid}, 0);
    edge_step();
    chk("R11", "halted", {31'd0, halted}, 1);
    chk("R11", "no push after", {31'd0, push0_valid | push1_valid}, 0);
    edge_step();
    chk("R11", "still halted", {31'd0, halted}, 1);
    chk("R11", "still silent", {31'd0, push0_valid | push1_valid}, 0);

    // R11 R6 halt first drops second
    restart();
    prog[0] = {6'h07, 26'd0};
    #1;
    chk("R11", "nothing pushed", {31'd0, push0_valid | push1_valid}, 0);
    edge_step();
    chk("R11", "halted", {31'd0, halted}, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule